// File: doc/BRIEF.md
# Broadcast Path Discovery Node

This block is one router of a small side network that sits next to a packet mesh. It carries one-flit control waves between a source router and a target router. The waves look for a fault-free route, ask for a packet to be sent again, or report that a target cannot be reached. Each node has five ports: north, east, south, west and local. A wave that the node has not seen before is copied to every other mesh port in the next cycle, so it spreads over the whole mesh.

The node keeps a small table of the waves it is carrying. The table has a fixed depth that does not depend on the mesh size. Each entry holds the wave's service code, its source, its target and the port it came in on, so a later backtrack can retrace the path. A wave whose target equals the node's own address is handed to local software on the local port instead of being flooded further. A cleanup wave erases every entry that shares its source and target pair, and it travels only as far as there are entries to erase. The input ports have no buffers. When several waves arrive in the same cycle, one is taken by a fixed priority and the rest are discarded.

Top module: `wave_flood_node`

## Requirements
- R1: After reset, all output valids, the delivery pulse and the overflow pulse are 0, the flit output is 0, and a lookup reports no hit.
- R2: A flit is {service[1:0], source[ADDR_W-1:0], target[ADDR_W-1:0]}, with the service in the top bits and the target in the bottom bits. Service codes: 00 resend request, 01 unreachable report, 10 route search, 11 cleanup. An emitted flit is an unchanged copy of the accepted input flit.
- R3: An accepted non-cleanup wave whose target differs from `local_addr_i` appears one cycle later on every mesh port except the one it arrived on, with the local valid low. Port index encoding: north 0, east 1, south 2, west 3, local 4. A wave injected on the local port goes out on all four mesh ports.
- R4: An accepted wave whose target equals `local_addr_i` raises only the local output valid and `deliver_o`, for one cycle.
- R5: An accepted non-cleanup wave is stored together with its arrival port index. A lookup on its {source, target} pair then reports a hit and that port. When several entries match, the lowest table slot answers.
- R6: A non-cleanup wave whose {service, source, target} is already stored is dropped: no output, no overflow, and the table is unchanged.
- R7: A wave with a stored {source, target} pair but a different service is a new wave and takes its own entry.
- R8: When all TABLE_DEPTH entries are in use, a new non-duplicate, non-cleanup wave is dropped with no output, and `overflow_o` pulses for one cycle.
- R9: A cleanup wave clears every entry whose {source, target} matches its own, whatever the entry's service, and leaves the other entries alone. The freed slots can be used again.
- R10: A cleanup wave that matches no entry is dropped with no output. A cleanup wave is never stored and never raises overflow.
- R11: When several inputs are valid in one cycle, the lowest port index wins (north, east, south, west, local). The other waves are discarded and are not stored.
- R12: A cleanup wave that cleared entries is forwarded or delivered under the same port rules as R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_addr_i | input | ADDR_W | Address of this node |
| in_valid_i | input | 5 | Per-port input valid, bit index = port index |
| in_flit_i | input | 5*FLIT_W | Per-port input flits, port p at bits [p*FLIT_W +: FLIT_W] |
| out_valid_o | output | 5 | Per-port output valid |
| out_flit_o | output | FLIT_W | Flit shared by all asserted outputs |
| deliver_o | output | 1 | Wave addressed to this node handed to the local port |
| overflow_o | output | 1 | Wave dropped because the table was full |
| lookup_src_i | input | ADDR_W | Source half of the retrace query |
| lookup_tgt_i | input | ADDR_W | Target half of the retrace query |
| lookup_hit_o | output | 1 | A stored wave matches the query pair |
| lookup_port_o | output | 3 | Arrival port of the matching entry |

## Verification
The bench sends waves from every port with every non-cleanup service. After each one it checks the exact output valid mask, because a design that leaves out the wrong bit, or echoes a wave back to its arrival port, would keep waves circling in the mesh. It repeats waves to catch a table that stores a duplicate, and it fills the table to confirm the overflow pulse and that a duplicate arriving on a full table raises no overflow. It sends cleanup waves that match no entry, which a faulty design would flood forever, and cleanup waves that share a pair with entries of several services, which a faulty design would clear only partly. It also sends every combination of simultaneous inputs and then queries each loser's pair, which exposes a wrong priority order or a loser that leaks into the table.

// File: rtl/wfn_pkg.sv
package wfn_pkg;
  localparam int unsigned NUM_PORTS  = 5;
  localparam int unsigned PORT_W     = 3;
  localparam int unsigned LOCAL_PORT = 4;
  localparam int unsigned SVC_W      = 2;

  typedef enum logic [SVC_W-1:0] {
    SVC_RESEND  = 2'b00,
    SVC_UNREACH = 2'b01,
    SVC_NEWPATH = 2'b10,
    SVC_CLEAN   = 2'b11
  } svc_e;
endpackage

// File: rtl/wfn_arbiter.sv
module wfn_arbiter #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index has priority
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      gnt_o[i] = req_i[i] & ~seen;
      seen     = seen | req_i[i];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (gnt_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/wfn_wave_table.sv
module wfn_wave_table #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PORT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pr_svc_i,
  input  logic [ADDR_W-1:0] pr_src_i,
  input  logic [ADDR_W-1:0] pr_tgt_i,
  input  logic              ins_en_i,
  input  logic [PORT_W-1:0] ins_port_i,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] lk_src_i,
  input  logic [ADDR_W-1:0] lk_tgt_i,
  output logic              dup_o,
  output logic              pair_o,
  output logic              full_o,
  output logic [DEPTH-1:0]  valid_o,
  output logic              lk_hit_o,
  output logic [PORT_W-1:0] lk_port_o
);
  typedef struct packed {
    logic              vld;
    logic [1:0]        svc;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] tgt;
    logic [PORT_W-1:0] port;
  } entry_t;

  entry_t [DEPTH-1:0] ent;
  logic   [DEPTH-1:0] pair_m, dup_m, lk_m, slot;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
    entry_t q;

    assign pair_m[g]  = q.vld && (q.src == pr_src_i) && (q.tgt == pr_tgt_i);
    assign dup_m[g]   = pair_m[g] && (q.svc == pr_svc_i);
    assign lk_m[g]    = q.vld && (q.src == lk_src_i) && (q.tgt == lk_tgt_i);
    assign valid_o[g] = q.vld;
    assign ent[g]     = q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (ins_en_i && slot[g]) begin
        q <= '{vld: 1'b1, svc: pr_svc_i, src: pr_src_i, tgt: pr_tgt_i, port: ins_port_i};
      end else if (clr_en_i && pair_m[g]) begin
        q.vld <= 1'b0;
      end
    end
  end

  // first free slot
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      slot[i] = ~valid_o[i] & ~taken;
      taken   = taken | ~valid_o[i];
    end
  end

  always_comb begin
    lk_port_o = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_port_o = ent[i].port;
    end
  end

  assign lk_hit_o = |lk_m;
  assign dup_o    = |dup_m;
  assign pair_o   = |pair_m;
  assign full_o   = &valid_o;
endmodule

// File: rtl/wfn_fanout.sv
module wfn_fanout #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LOCAL = 4
) (
  input  logic [IDX_W-1:0] arr_i,
  input  logic             to_local_i,
  output logic [N-1:0]     mask_o
);
  for (genvar g = 0; g < int'(N); g++) begin : g_port
    if (g == int'(LOCAL)) begin : g_loc
      assign mask_o[g] = to_local_i;
    end else begin : g_mesh
      assign mask_o[g] = ~to_local_i && (arr_i != IDX_W'(g));
    end
  end
endmodule

// File: rtl/wave_flood_node.sv
module wave_flood_node
  import wfn_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned TABLE_DEPTH = 4,
  parameter int unsigned FLIT_W      = SVC_W + 2 * ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             local_addr_i,
  input  logic [NUM_PORTS-1:0]          in_valid_i,
  input  logic [NUM_PORTS*FLIT_W-1:0]   in_flit_i,
  output logic [NUM_PORTS-1:0]          out_valid_o,
  output logic [FLIT_W-1:0]             out_flit_o,
  output logic                          deliver_o,
  output logic                          overflow_o,
  input  logic [ADDR_W-1:0]             lookup_src_i,
  input  logic [ADDR_W-1:0]             lookup_tgt_i,
  output logic                          lookup_hit_o,
  output logic [PORT_W-1:0]             lookup_port_o
);
  logic [NUM_PORTS-1:0] gnt;
  logic [PORT_W-1:0]    win_idx;
  logic                 any_req;
  logic [FLIT_W-1:0]    cur;
  logic [1:0]           cur_svc;
  logic [ADDR_W-1:0]    cur_src, cur_tgt;
  logic                 dup_hit, pair_hit, tbl_full;
  logic [TABLE_DEPTH-1:0] tbl_valid;
  logic                 is_clean, to_local, ins_en, clr_en, emit, ovf_d;
  logic [NUM_PORTS-1:0] fan_mask;

  wfn_arbiter #(.N(NUM_PORTS), .IDX_W(PORT_W)) u_arb (
    .req_i (in_valid_i),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any_req)
  );

  always_comb begin
    cur = '0;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      if (gnt[i]) cur = cur | in_flit_i[i*FLIT_W +: FLIT_W];
    end
  end

  assign cur_svc = cur[FLIT_W-1 -: SVC_W];
  assign cur_src = cur[2*ADDR_W-1 -: ADDR_W];
  assign cur_tgt = cur[ADDR_W-1:0];

  assign is_clean = (svc_e'(cur_svc) == SVC_CLEAN);
  assign to_local = (cur_tgt == local_addr_i);

  wfn_wave_table #(.ADDR_W(ADDR_W), .DEPTH(TABLE_DEPTH), .PORT_W(PORT_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pr_svc_i   (cur_svc),
    .pr_src_i   (cur_src),
    .pr_tgt_i   (cur_tgt),
    .ins_en_i   (ins_en),
    .ins_port_i (win_idx),
    .clr_en_i   (clr_en),
    .lk_src_i   (lookup_src_i),
    .lk_tgt_i   (lookup_tgt_i),
    .dup_o      (dup_hit),
    .pair_o     (pair_hit),
    .full_o     (tbl_full),
    .valid_o    (tbl_valid),
    .lk_hit_o   (lookup_hit_o),
    .lk_port_o  (lookup_port_o)
  );

  // new waves only; cleanup travels only while it still erases something
  assign ins_en = any_req && !is_clean && !dup_hit && !tbl_full;
  assign ovf_d  = any_req && !is_clean && !dup_hit &&  tbl_full;
  assign clr_en = any_req &&  is_clean && pair_hit;
  assign emit   = ins_en || clr_en;

  wfn_fanout #(.N(NUM_PORTS), .IDX_W(PORT_W), .LOCAL(LOCAL_PORT)) u_fan (
    .arr_i      (win_idx),
    .to_local_i (to_local),
    .mask_o     (fan_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_flit_o  <= '0;
      deliver_o   <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      out_valid_o <= emit ? fan_mask : '0;
      deliver_o   <= emit && to_local;
      overflow_o  <= ovf_d;
      if (emit) out_flit_o <= cur;
    end
  end
endmodule

// File: rtl/wfn_checks.sv
module wfn_checks #(
  parameter int unsigned NP    = 5,
  parameter int unsigned DEPTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NP-1:0]    in_valid_i,
  input logic [NP-1:0]    out_valid_o,
  input logic             deliver_o,
  input logic             overflow_o,
  input logic [NP-1:0]    gnt,
  input logic [DEPTH-1:0] tbl_valid
);
  assert_single_winner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  assert_output_needs_input_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_valid_o) |-> $past(|in_valid_i));

  assert_mesh_fanout_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|out_valid_o) && !out_valid_o[NP-1]) |-> ($countones(out_valid_o) >= 3));

  assert_deliver_local_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> (out_valid_o == NP'(1) << (NP-1)));

  assert_local_means_deliver_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[NP-1] |-> deliver_o);

  assert_overflow_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (out_valid_o == '0 && !deliver_o));

  assert_overflow_needs_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(&tbl_valid) && $past(|in_valid_i)));

  assert_table_grows_by_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tbl_valid) <= $past($countones(tbl_valid)) + 1);
endmodule

bind wave_flood_node wfn_checks #(.NP(wfn_pkg::NUM_PORTS), .DEPTH(TABLE_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .deliver_o   (deliver_o),
  .overflow_o  (overflow_o),
  .gnt         (gnt),
  .tbl_valid   (tbl_valid)
);

// File: tb/wave_flood_node_bench.sv
module wave_flood_node_bench;
  localparam int FW = 10;
  localparam logic [3:0] LOC = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  in_valid = '0;
  logic [5*FW-1:0] in_flit = '0;
  logic [4:0]  out_valid;
  logic [FW-1:0] out_flit;
  logic        deliver, overflow;
  logic [3:0]  lk_src = '0, lk_tgt = '0;
  logic        lk_hit;
  logic [2:0]  lk_port;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wave_flood_node u_wave_flood_node (
    .clk_i(clk), .rst_ni(rst_n), .local_addr_i(LOC),
    .in_valid_i(in_valid), .in_flit_i(in_flit),
    .out_valid_o(out_valid), .out_flit_o(out_flit),
    .deliver_o(deliver), .overflow_o(overflow),
    .lookup_src_i(lk_src), .lookup_tgt_i(lk_tgt),
    .lookup_hit_o(lk_hit), .lookup_port_o(lk_port)
  );

  // reference table
  bit         m_v[4];
  logic [1:0] m_s[4];
  logic [3:0] m_a[4], m_b[4];
  int         m_p[4];
  logic [4:0] e_valid;
  logic [FW-1:0] e_flit;
  bit         e_del, e_ovf;

  function automatic logic [FW-1:0] mk(input int svc, input logic [3:0] s, input logic [3:0] t);
    return {2'(svc), s, t};
  endfunction

  function automatic logic [5*FW-1:0] place(input int p, input logic [FW-1:0] f);
    logic [5*FW-1:0] v;
    v = '0;
    v[p*FW +: FW] = f;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [4:0] vm, input logic [5*FW-1:0] fl);
    int w, free;
    bit dup, pair, emit;
    logic [FW-1:0] f;
    w = -1;
    for (int i = 0; i < 5; i++) if (vm[i] && w < 0) w = i;
    e_valid = '0; e_del = 0; e_ovf = 0; e_flit = '0;
    if (w < 0) return;
    f = fl[w*FW +: FW];
    dup = 0; pair = 0; free = -1; emit = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_v[i] && m_a[i] == f[7:4] && m_b[i] == f[3:0]) begin
        pair = 1;
        if (m_s[i] == f[9:8]) dup = 1;
      end
      if (!m_v[i] && free < 0) free = i;
    end
    if (f[9:8] == 2'b11) begin
      if (pair) begin
        emit = 1;
        for (int i = 0; i < 4; i++)
          if (m_v[i] && m_a[i] == f[7:4] && m_b[i] == f[3:0]) m_v[i] = 0;
      end
    end else if (!dup) begin
      if (free < 0) e_ovf = 1;
      else begin
        m_v[free] = 1; m_s[free] = f[9:8]; m_a[free] = f[7:4];
        m_b[free] = f[3:0]; m_p[free] = w; emit = 1;
      end
    end
    if (emit) begin
      e_flit = f;
      if (f[3:0] == LOC) begin
        e_valid = 5'b10000; e_del = 1;
      end else begin
        e_valid = 5'b01111;
        if (w < 4) e_valid[w] = 1'b0;
      end
    end
  endtask

  task automatic step(input logic [4:0] vm, input logic [5*FW-1:0] fl, input string tag);
    @(negedge clk);
    in_valid = vm;
    in_flit  = fl;
    model(vm, fl);
    @(negedge clk);
    in_valid = '0;
    check(out_valid == e_valid, tag, "out_valid", 32'(out_valid), 32'(e_valid));
    check(deliver == e_del, tag, "deliver", 32'(deliver), 32'(e_del));
    check(overflow == e_ovf, tag, "overflow", 32'(overflow), 32'(e_ovf));
    if (e_valid != '0)
      check(out_flit == e_flit, tag, "flit", 32'(out_flit), 32'(e_flit));
  endtask

  task automatic lk(input logic [3:0] s, input logic [3:0] t, input string tag);
    bit h;
    int p;
    h = 0; p = 0;
    for (int i = 3; i >= 0; i--)
      if (m_v[i] && m_a[i] == s && m_b[i] == t) begin h = 1; p = m_p[i]; end
    lk_src = s;
    lk_tgt = t;
    #1;
    check(lk_hit == h, tag, "lookup_hit", 32'(lk_hit), 32'(h));
    if (h) check(int'(lk_port) == p, tag, "lookup_port", 32'(lk_port), 32'(p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == '0 && out_flit == '0, "R1", "outs in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0 && !deliver && !overflow, "R1", "outs after reset",
          32'({out_valid, deliver, overflow}), 0);
    lk(4'h1, 4'hC, "R1");

    // R3 R5 R6 R9 R12: every port, every search service
    for (int p = 0; p < 5; p++) begin
      for (int s = 0; s < 3; s++) begin
        logic [3:0] src;
        int cp;
        src = 4'(p + 1);
        cp = (p + 1) % 5;
        step(5'(1 << p), place(p, mk(s, src, 4'hC)), "R3");
        lk(src, 4'hC, "R5");
        step(5'(1 << p), place(p, mk(s, src, 4'hC)), "R6");
        lk(src, 4'hC, "R6");
        step(5'(1 << cp), place(cp, mk(3, src, 4'hC)), "R12");
        lk(src, 4'hC, "R9");
      end
    end

    // R2 field layout
    step(5'b01000, place(3, mk(2, 4'h9, 4'hB)), "R2");
    step(5'b00001, place(0, mk(3, 4'h9, 4'hB)), "R2");

    // R4 delivery, R12 cleanup at target
    for (int p = 0; p < 5; p++) begin
      step(5'(1 << p), place(p, mk(p % 3, 4'h2, LOC)), "R4");
      lk(4'h2, LOC, "R4");
      step(5'(1 << p), place(p, mk(3, 4'h2, LOC)), "R12");
    end

    // R7 R8 R10 R9
    step(5'b00001, place(0, mk(0, 4'h1, 4'h7)), "R7");
    step(5'b00010, place(1, mk(1, 4'h1, 4'h7)), "R7");
    step(5'b00100, place(2, mk(2, 4'h1, 4'h7)), "R7");
    lk(4'h1, 4'h7, "R7");
    step(5'b01000, place(3, mk(0, 4'h2, 4'h7)), "R8");
    step(5'b00010, place(1, mk(1, 4'h3, 4'h7)), "R8");
    lk(4'h3, 4'h7, "R8");
    step(5'b10000, place(4, mk(0, 4'h2, 4'h7)), "R6");
    step(5'b00001, place(0, mk(3, 4'h4, 4'h7)), "R10");
    step(5'b00100, place(2, mk(3, 4'h1, 4'h7)), "R9");
    lk(4'h1, 4'h7, "R9");
    lk(4'h2, 4'h7, "R9");
    step(5'b00010, place(1, mk(1, 4'h3, 4'h7)), "R8");
    lk(4'h3, 4'h7, "R8");
    step(5'b00001, place(0, mk(3, 4'h2, 4'h7)), "R9");
    step(5'b00001, place(0, mk(3, 4'h3, 4'h7)), "R9");

    // R11 all input combinations
    for (int m = 1; m < 32; m++) begin
      logic [5*FW-1:0] fl;
      int w;
      fl = '0;
      w = -1;
      for (int i = 0; i < 5; i++) begin
        fl[i*FW +: FW] = mk(i % 3, 4'(i + 8), 4'hA);
        if (m[i] && w < 0) w = i;
      end
      step(5'(m), fl, "R11");
      for (int i = 0; i < 5; i++) lk(4'(i + 8), 4'hA, "R11");
      step(5'b00001, place(0, mk(3, 4'(w + 8), 4'hA)), "R12");
    end

    // R10 cleanup into empty table from local port
    step(5'b10000, place(4, mk(3, 4'hE, 4'hA)), "R10");
    lk(4'hE, 4'hA, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule